// File: doc/BRIEF.md
# Linear Array Pixel Readout Sequencer

This block is the digital timing core of a 64-element linear light-sensor array. A single start pulse, seen high at a rising clock edge while the block is idle, launches one token into a chain of flip-flops. The token moves one stage per rising edge, and each stage selects one pixel onto the shared analog output. A separate counter produces a binary pixel index and an output-enable window that covers exactly the 64 readout cycles. The block then returns to idle.

The last stage of the chain doubles as a carry pulse. That pulse can drive the start input of a following array, so several devices can share one analog line and read out one after another. Two clock-phase strobes are derived for the analog side. A sense-node reset is issued in the low half of every cycle. A sample strobe is issued in the high half of each readout cycle, and the held value stays stable while the clock is low.

Top module: `linear_scan_seq`

## Requirements
- R1: While rst_ni is low, sel_o is all zero, oe_o is 0, idx_o is 0 and carry_o is 0, whatever start_i does.
- R2: When start_i is 1 at a rising edge and no pixel is selected, the next cycle shows sel_o bit 0 set (one-hot), oe_o = 1 and idx_o = 0.
- R3: Each later rising edge of a scan moves the single set bit of sel_o up by one position, and idx_o increments with it, so idx_o always equals the position of the set bit while oe_o is 1.
- R4: carry_o is 1 only in the cycle after the 64th edge of a scan, the cycle in which pixel 63 is selected.
- R5: The 65th edge of a scan clears sel_o and drops both oe_o and carry_o to 0.
- R6: start_i high at the 65th edge is not taken; start_i high at the 66th edge begins a new scan at pixel 0.
- R7: start_i pulsing while a scan is in progress injects no second token and leaves the pixel order unchanged.
- R8: oe_o is high for exactly 64 consecutive cycles per scan and low at all other times.
- R9: node_rst_o equals 1 while clk_i is low and 0 while clk_i is high, in every cycle. sh_o is 1 only while clk_i is high and oe_o is 1. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Serial start pulse |
| sel_o | output | 64 | One-hot pixel select, bit n = pixel n |
| oe_o | output | 1 | Analog output stage enable |
| idx_o | output | 7 | Binary index of the selected pixel, valid while oe_o is 1 |
| carry_o | output | 1 | Cascade pulse for the start input of the next device |
| sh_o | output | 1 | Sample strobe (sample high, hold low) |
| node_rst_o | output | 1 | Sense-node reset strobe |

## Verification
The terminating 65th edge and a new start request can fall in the same cycle, and so can the 66th-edge restart and the idle return. These cases are provoked by holding start_i high across edges 64, 65 and 66 at the end of one scan. The expected trace shows an empty select vector after edge 65 and pixel 0 after edge 66. Any early acceptance or late clearing then shows up as a select or enable mismatch. A mid-scan start pulse is driven the same way, and the expected trace checks that the pixel order continues undisturbed.

// File: rtl/lscan_pkg.sv
package lscan_pkg;
  localparam int unsigned PIX_N_DEF = 64;

  function automatic int unsigned idx_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lscan_token_chain.sv
module lscan_token_chain #(
  parameter int unsigned PIX_N = lscan_pkg::PIX_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [PIX_N-1:0] sel_o
);
  logic [PIX_N-1:0] stage_q;

  for (genvar g = 0; g < PIX_N; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_head
      assign d = load_i;
    end else begin : g_body
      assign d = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= d;
    end
  end

  assign sel_o = stage_q;

  // R7: never more than one token in flight
  a_r7_single_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stage_q));
endmodule

// File: rtl/lscan_scan_timer.sv
module lscan_scan_timer #(
  parameter int unsigned PIX_N = lscan_pkg::PIX_N_DEF,
  localparam int unsigned IDX_W = lscan_pkg::idx_width(PIX_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic             oe_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PIX_N - 1);

  logic             oe_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      idx_q <= '0;
    end else if (load_i) begin
      oe_q  <= 1'b1;
      idx_q <= '0;
    end else if (oe_q) begin
      if (idx_q == LAST) begin
        oe_q  <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign oe_o  = oe_q;
  assign idx_o = idx_q;

  // R8: index stays in range while the window is open
  a_r8_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (idx_q <= LAST));
endmodule

// File: rtl/lscan_strobe_gen.sv
module lscan_strobe_gen (
  input  logic clk_i,
  input  logic oe_i,
  output logic sh_o,
  output logic node_rst_o
);
  // sample in high phase, reset node in low phase: phases never overlap
  assign sh_o       = clk_i & oe_i;
  assign node_rst_o = ~clk_i;
endmodule

// File: rtl/linear_scan_seq.sv
module linear_scan_seq #(
  parameter int unsigned PIX_N = lscan_pkg::PIX_N_DEF,
  localparam int unsigned IDX_W = lscan_pkg::idx_width(PIX_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [PIX_N-1:0] sel_o,
  output logic             oe_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             carry_o,
  output logic             sh_o,
  output logic             node_rst_o
);
  logic busy;
  logic load;

  assign busy = |sel_o;
  assign load = start_i & ~busy;   // retrigger lockout while a token is in flight

  lscan_token_chain #(.PIX_N(PIX_N)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .sel_o  (sel_o)
  );

  lscan_scan_timer #(.PIX_N(PIX_N)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .oe_o   (oe_o),
    .idx_o  (idx_o)
  );

  lscan_strobe_gen u_strobe (
    .clk_i      (clk_i),
    .oe_i       (oe_o),
    .sh_o       (sh_o),
    .node_rst_o (node_rst_o)
  );

  assign carry_o = sel_o[PIX_N-1];

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (sel_o[0] && oe_o && idx_o == '0));

  a_r3_sel_matches_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (sel_o == ({{(PIX_N-1){1'b0}}, 1'b1} << idx_o)));

  a_r4_carry_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (!carry_o && !oe_o && sel_o == '0));

  a_r5_close_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> (sel_o == '0));

  a_r7_no_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !sel_o[0]);

  a_r8_oe_tracks_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o == busy);
endmodule

// File: tb/linear_scan_seq_tb_top.sv
module linear_scan_seq_tb_top;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  sel;
  logic          oe;
  logic [6:0]    idx;
  logic          carry;
  logic          sh;
  logic          nrst;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit    oe;
    int    idx;
    bit    carry;
    string tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  linear_scan_seq #(.PIX_N(N)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .sel_o      (sel),
    .oe_o       (oe),
    .idx_o      (idx),
    .carry_o    (carry),
    .sh_o       (sh),
    .node_rst_o (nrst)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: high phase at posedge+1, low phase at posedge+6
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [N-1:0] es;
      e  = q.pop_front();
      es = e.oe ? (N'(1) << e.idx) : '0;
      chk(sel == es, e.tag, "sel", 0, 0);
      if (sel != es) $display("  sel=%h exp=%h", sel, es);
      chk(oe == e.oe, e.tag, "oe", oe, e.oe);
      if (e.oe) chk(idx == 7'(e.idx), e.tag, "idx", idx, e.idx);
      chk(carry == e.carry, e.tag, "carry", carry, e.carry);
      chk(sh == e.oe && nrst == 1'b0, "R9", "high-phase sh", sh, e.oe);
      #5;
      chk(sh == 1'b0 && nrst == 1'b1, "R9", "low-phase nrst", nrst, 1);
    end
  end

  // drive start for the next edge and push what that edge must produce
  task automatic step(input bit s, input bit eo, input int ei, input bit ec,
                      input string tag);
    @(posedge clk); #2;
    start = s;
    q.push_back('{oe: eo, idx: ei, carry: ec, tag: tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 1'b0, "R8");
  endtask

  // one full scan; first step is the start edge
  task automatic scan(input bit hold_end, input int poke_at);
    step(1'b1, 1'b1, 0, 1'b0, "R2");
    for (int k = 1; k < N; k++) begin
      bit p;
      p = (poke_at == k) || (hold_end && k == N - 1);
      step(p, 1'b1, k, k == N - 1, (k == N - 1) ? "R4" : (poke_at > 0 ? "R7" : "R3"));
    end
    // edge 65: start (if held) must be ignored
    step(hold_end, 1'b0, 0, 1'b0, hold_end ? "R6" : "R5");
  endtask

  initial begin
    // R1: reset state with start toggling
    #2 start = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk(sel == '0 && oe == 1'b0 && idx == '0 && carry == 1'b0, "R1", "reset state",
        {oe, carry}, 0);
    start = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    idle(3);
    scan(1'b0, 0);
    idle(4);
    scan(1'b0, 20);                 // R7 mid-scan poke
    scan(1'b1, 0);                  // R6 held through 65, accepted on 66 by next scan
    scan(1'b1, 5);                  // back-to-back again, with poke
    scan(1'b0, 0);
    idle(5);
    // R1: asynchronous reset mid-scan
    step(1'b1, 1'b1, 0, 1'b0, "R2");
    for (int k = 1; k < 10; k++) step(1'b0, 1'b1, k, 1'b0, "R3");
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1;
    chk(sel == '0 && oe == 1'b0 && carry == 1'b0, "R1", "async reset", oe, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    idle(3);
    scan(1'b0, 0);
    idle(3);
    @(posedge clk); #8;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule